// File: doc/BRIEF.md
# DMA Trigger Source Dispatcher

This block sits between a set of event sources and the transfer sequencer of a multi-channel DMA engine. The event sources are an external request pin, the transmit-empty and receive-full flags of two serial ports, and a timer input-capture strobe. Each one arrives as a single-cycle pulse. Each channel presents a control word that holds an enable field, a 4-bit request-source code and an auto-request field. A global operation field gates every channel at once.

All channels are evaluated side by side in every cycle. Each channel that is enabled, and whose source code matches the event present in that cycle, gets a one-unit run request. That request is latched until the sequencer acknowledges it, and further matching events that arrive meanwhile fold into it. A second registered output marks the channels that are set for auto-request, so the sequencer can start them without waiting for an event. Moving the data and choosing between channels are left to the sequencer.

Top module: `dma_trig_dispatch`

## Requirements
- R1: In the cycle after reset, `run_req` and `auto_flag` are all zero.
- R2: An external request pulse raises a run request only on channels whose source code (control bits 11:8) is 0x0.
- R3: The serial events match one exact code each: port A transmit-empty matches 0x8, port A receive-full 0x9, port B transmit-empty 0xA, port B receive-full 0xB.
- R4: A timer capture pulse raises a run request on every qualifying channel whose code is 0xC or higher.
- R5: No event raises any request unless `glob_ctl` equals 3'b001.
- R6: A channel takes requests only while its control bits 1:0 equal 2'b01. The values 00, 10 and 11 block it.
- R7: One event raises requests on several channels in the same cycle when several channels match.
- R8: A matching event present during one clock cycle sets `run_req` at the clock edge that ends that cycle.
- R9: A raised `run_req` stays high until `run_ack` is high for that channel, and it is low after that edge.
- R10: Repeated matching events while a request is pending leave a single request, which one acknowledge clears. A new matching event in the same cycle as the acknowledge keeps the request high.
- R11: `auto_flag[i]` is registered high exactly when control bits 11:10 of channel i equal 2'b01 (codes 0x4 to 0x7), the channel enable field is 2'b01 and the global field is 3'b001.
- R12: Codes 0x1 to 0x7 are never raised by any event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_ext | input | 1 | External request pulse |
| ev_pa_txe | input | 1 | Serial port A transmit-empty pulse |
| ev_pa_rxf | input | 1 | Serial port A receive-full pulse |
| ev_pb_txe | input | 1 | Serial port B transmit-empty pulse |
| ev_pb_rxf | input | 1 | Serial port B receive-full pulse |
| ev_tmr_cap | input | 1 | Timer input-capture pulse |
| glob_ctl | input | GLOB_W | Global operation field; dispatch is on only at 3'b001 |
| chan_ctl | input | NUM_CH*16 | Control words, channel i in bits [16i+15:16i] |
| run_ack | input | NUM_CH | Sequencer acknowledge, one bit per channel |
| run_req | output | NUM_CH | Pending one-unit run request per channel |
| auto_flag | output | NUM_CH | Channel qualified for auto-request |

## Verification
Both outputs have a latency of one register. A request from an event driven during cycle t shows up after the edge that closes cycle t. An auto flag follows a control-word change after one edge. The bench changes inputs on falling edges, keeps each event for one full cycle, and samples on the next falling edge, which is half a period after the edge that should have updated the output. Clearing is checked one falling edge after the acknowledge cycle. The sweep covers every code with every event, every enable field value, and both legal and illegal global values.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int CTL_W     = 16;
  localparam int CODE_LO   = 8;
  localparam int CODE_W    = 4;
  localparam int AUTO_LO   = 10;
  localparam int EN_LO     = 0;
  localparam int N_EV      = 6;

  typedef enum logic [2:0] {
    EV_EXT    = 3'd0,
    EV_PA_TXE = 3'd1,
    EV_PA_RXF = 3'd2,
    EV_PB_TXE = 3'd3,
    EV_PB_RXF = 3'd4,
    EV_TMR    = 3'd5
  } ev_idx_e;

  localparam logic [CODE_W-1:0] SRC_EXT    = 4'h0;
  localparam logic [CODE_W-1:0] SRC_PA_TXE = 4'h8;
  localparam logic [CODE_W-1:0] SRC_PA_RXF = 4'h9;
  localparam logic [CODE_W-1:0] SRC_PB_TXE = 4'hA;
  localparam logic [CODE_W-1:0] SRC_PB_RXF = 4'hB;
  localparam logic [CODE_W-1:0] SRC_TMR_LO = 4'hC;

  localparam logic [1:0] CH_EN_VAL   = 2'b01;
  localparam logic [1:0] AUTO_VAL    = 2'b01;
endpackage

// File: rtl/dma_trig_match.sv
module dma_trig_match
  import dma_trig_pkg::*;
(
  input  logic [CTL_W-1:0] ctl,
  input  logic [N_EV-1:0]  ev,
  input  logic             gate,
  output logic             hit,
  output logic             is_auto
);
  logic [CODE_W-1:0] code;
  logic              ch_on;
  logic [N_EV-1:0]   sel;
  logic              ctl_unused;

  assign code  = ctl[CODE_LO +: CODE_W];
  assign ch_on = gate && (ctl[EN_LO +: 2] == CH_EN_VAL);
  assign ctl_unused = ^{ctl[CTL_W-1:CODE_LO+CODE_W], ctl[CODE_LO-1:EN_LO+2]};

  always_comb begin
    sel            = '0;
    sel[EV_EXT]    = (code == SRC_EXT);
    sel[EV_PA_TXE] = (code == SRC_PA_TXE);
    sel[EV_PA_RXF] = (code == SRC_PA_RXF);
    sel[EV_PB_TXE] = (code == SRC_PB_TXE);
    sel[EV_PB_RXF] = (code == SRC_PB_RXF);
    sel[EV_TMR]    = (code >= SRC_TMR_LO);
  end

  assign hit     = ch_on && |(sel & ev);
  assign is_auto = ch_on && (ctl[AUTO_LO +: 2] == AUTO_VAL);
endmodule

// File: rtl/dma_trig_pend.sv
module dma_trig_pend (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic ack,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= hit | (pend & ~ack);
  end

  p_rise_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(hit));
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (pend && !ack) |=> pend);
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (pend && ack && !hit) |=> !pend);
  p_ack_with_hit_r10: assert property (@(posedge clk) disable iff (rst)
    hit |=> pend);
endmodule

// File: rtl/dma_trig_dispatch.sv
module dma_trig_dispatch
  import dma_trig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int GLOB_W = 3,
  parameter logic [GLOB_W-1:0] GLOB_ON = 3'b001
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_ext,
  input  logic                    ev_pa_txe,
  input  logic                    ev_pa_rxf,
  input  logic                    ev_pb_txe,
  input  logic                    ev_pb_rxf,
  input  logic                    ev_tmr_cap,
  input  logic [GLOB_W-1:0]       glob_ctl,
  input  logic [NUM_CH*CTL_W-1:0] chan_ctl,
  input  logic [NUM_CH-1:0]       run_ack,
  output logic [NUM_CH-1:0]       run_req,
  output logic [NUM_CH-1:0]       auto_flag
);
  logic [N_EV-1:0]   ev_vec;
  logic              glob_ok;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] auto_d;

  always_comb begin
    ev_vec            = '0;
    ev_vec[EV_EXT]    = ev_ext;
    ev_vec[EV_PA_TXE] = ev_pa_txe;
    ev_vec[EV_PA_RXF] = ev_pa_rxf;
    ev_vec[EV_PB_TXE] = ev_pb_txe;
    ev_vec[EV_PB_RXF] = ev_pb_rxf;
    ev_vec[EV_TMR]    = ev_tmr_cap;
  end

  assign glob_ok = (glob_ctl == GLOB_ON);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_trig_match u_match (
      .ctl     (chan_ctl[i*CTL_W +: CTL_W]),
      .ev      (ev_vec),
      .gate    (glob_ok),
      .hit     (hit[i]),
      .is_auto (auto_d[i])
    );

    dma_trig_pend u_pend (
      .clk  (clk),
      .rst  (rst),
      .hit  (hit[i]),
      .ack  (run_ack[i]),
      .pend (run_req[i])
    );

    p_glob_gate_r5: assert property (@(posedge clk) disable iff (rst)
      !glob_ok |=> !$rose(run_req[i]));
    p_chan_gate_r6: assert property (@(posedge clk) disable iff (rst)
      (chan_ctl[i*CTL_W + EN_LO +: 2] != CH_EN_VAL) |=> !$rose(run_req[i]));
    p_ext_match_r2: assert property (@(posedge clk) disable iff (rst)
      (ev_ext && glob_ok && chan_ctl[i*CTL_W +: 2] == CH_EN_VAL
       && chan_ctl[i*CTL_W + CODE_LO +: CODE_W] == SRC_EXT) |=> run_req[i]);
    p_tmr_match_r4: assert property (@(posedge clk) disable iff (rst)
      (ev_tmr_cap && glob_ok && chan_ctl[i*CTL_W +: 2] == CH_EN_VAL
       && chan_ctl[i*CTL_W + CODE_LO +: CODE_W] >= SRC_TMR_LO) |=> run_req[i]);
    p_low_codes_r12: assert property (@(posedge clk) disable iff (rst)
      (chan_ctl[i*CTL_W + CODE_LO +: CODE_W] inside {[4'h1:4'h7]}) |=> !$rose(run_req[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) auto_flag <= '0;
    else     auto_flag <= auto_d;
  end

  p_auto_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !glob_ok |=> (auto_flag == '0));
endmodule

// File: tb/tb_dma_trig_dispatch.sv
module tb_dma_trig_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] ev = '0;
  logic [2:0] glob = '0;
  logic [NCH*16-1:0] ctl = '0;
  logic [NCH-1:0] ack = '0;
  logic [NCH-1:0] run_req;
  logic [NCH-1:0] auto_flag;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_dispatch dut (
    .clk(clk), .rst(rst),
    .ev_ext(ev[0]), .ev_pa_txe(ev[1]), .ev_pa_rxf(ev[2]),
    .ev_pb_txe(ev[3]), .ev_pb_rxf(ev[4]), .ev_tmr_cap(ev[5]),
    .glob_ctl(glob), .chan_ctl(ctl), .run_ack(ack),
    .run_req(run_req), .auto_flag(auto_flag)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_hit(int code, int en, int g, int e);
    if (g != 1 || en != 1) return 1'b0;
    case (e)
      0: return code == 0;
      1: return code == 8;
      2: return code == 9;
      3: return code == 10;
      4: return code == 11;
      default: return code >= 12;
    endcase
  endfunction

  function automatic logic [15:0] mk_ctl(int code, int en);
    return 16'((code & 15) << 8) | 16'(en & 3);
  endfunction

  task automatic pulse(logic [5:0] e, logic [NCH-1:0] a);
    @(negedge clk); ev = e; ack = a;
    @(negedge clk); ev = '0; ack = '0;
  endtask

  initial begin
    int bad_g [4] = '{0, 3, 5, 2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 run_req after reset", 32'(run_req), 0);
    check("R1 auto_flag after reset", 32'(auto_flag), 0);

    // Full sweep: R2 R3 R4 R5 R6 R11 R12
    for (int c = 0; c < 16; c++)
      for (int e = 0; e < 6; e++)
        for (int en = 0; en < 4; en++)
          for (int gs = 0; gs < 2; gs++) begin
            int gv;
            logic [NCH-1:0] xr, xa;
            gv = gs ? 1 : bad_g[(c + e + en) % 4];
            xr = '0; xa = '0;
            @(negedge clk);
            glob = 3'(gv);
            for (int i = 0; i < NCH; i++) begin
              int ci, ei;
              ci = (c + 4*i) % 16;
              ei = (en + i) % 4;
              ctl[i*16 +: 16] = mk_ctl(ci, ei);
              xr[i] = exp_hit(ci, ei, gv, e);
              xa[i] = (gv == 1) && (ei == 1) && (ci >= 4) && (ci <= 7);
            end
            @(negedge clk); ev = 6'(1 << e);
            @(negedge clk); ev = '0;
            check("R2/R3/R4/R5/R6/R12 run_req vs event and code", 32'(run_req), 32'(xr));
            check("R11 auto_flag", 32'(auto_flag), 32'(xa));
            ack = '1;
            @(negedge clk); ack = '0;
            check("R9 ack clears", 32'(run_req), 0);
          end

    // R7: timer fires all four channels at once
    glob = 3'b001;
    for (int i = 0; i < NCH; i++) ctl[i*16 +: 16] = mk_ctl(12 + i, 1);
    pulse(6'b100000, '0);
    check("R7 all channels together", 32'(run_req), 32'hF);
    pulse(6'b000000, '1);
    check("R7 cleared", 32'(run_req), 0);

    // R8: request visible right after the edge closing the event cycle
    for (int i = 0; i < NCH; i++) ctl[i*16 +: 16] = mk_ctl(0, 1);
    @(negedge clk); ev = 6'b000001;
    @(posedge clk); #1;
    check("R8 registered at closing edge", 32'(run_req), 32'hF);
    @(negedge clk); ev = '0;

    // R9: hold without ack
    repeat (4) @(negedge clk);
    check("R9 held without ack", 32'(run_req), 32'hF);

    // R10: duplicates merged, one ack clears
    pulse(6'b000001, '0);
    pulse(6'b000001, '0);
    check("R10 still single pending", 32'(run_req), 32'hF);
    pulse(6'b000000, 4'b0001);
    check("R10 one ack clears merged", 32'(run_req), 32'hE);
    // event concurrent with ack keeps request
    pulse(6'b000001, 4'b0010);
    check("R10 event with ack keeps", 32'(run_req), 32'hF);
    pulse(6'b000000, '1);
    @(negedge clk);
    check("R10 no ghost request", 32'(run_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule